// File: doc/BRIEF.md
# Fetch-Steered Page Map Translator

This block sits between a CPU with a 16-bit byte address space and a physical memory system. It breaks the CPU space into 512-byte pages and sends every access through one entry of a page table. Each entry holds an attribute (RAM, ROM or empty) and a physical page base. Four tables are held in registers. At any moment two of them form the active pair, and one member of that pair serves the access.

The member is chosen by where the CPU last fetched an opcode. The address of every opcode fetch is captured. While that captured address lies in the 2 KiB window starting at 0x7800, the odd table of the pair is used; otherwise the even table is used. Code running from that window therefore sees its own memory layout. A level input, `extOpen`, moves the active pair from tables 0/1 to tables 2/3, which opens an extended area.

Writes to ROM pages are dropped before they reach memory. Empty pages never strobe memory and read back as 0xFF. The tables are filled through a simple load port before or during use.

Top module: `mmsel_top`

## Requirements
- R1: The upper 7 address bits index the page entry. `memAddr` is the entry's 8-bit base concatenated with `cpuAddr[8:0]`.
- R2: `m1Addr` takes `cpuAddr` at a rising clock edge where `cpuM1` and `cpuRd` are both high. Reads without `cpuM1`, writes and idle cycles leave it unchanged.
- R3: When `(m1Addr & 0xF800) == 0x7800` the odd table of the active pair is used; otherwise the even table is used.
- R4: The table used has index `2*extOpen + alt`, where alt is the R3 outcome, so `extOpen` high selects tables 2 and 3.
- R5: On a page with attribute 01 (ROM), a write leaves `memWr` low and a read raises `memRd`.
- R6: On a page with attribute 10 or 11 (empty), neither `memRd` nor `memWr` rises, and a read returns 0xFF on `cpuRdata`.
- R7: After reset, `m1Addr` is 0x0000. Every entry of table m at page p is RAM with base `(m mod 2)*128 + p`.
- R8: The table choice for an access comes from the `m1Addr` value held before that cycle's edge, so an opcode fetch is translated by the earlier selection.
- R9: On a page with attribute 00 (RAM), `memRd` follows `cpuRd`, `memWr` follows `cpuWr`, `memWdata` equals `cpuWdata` and `cpuRdata` equals `memRdata`.
- R10: With `tblWe` high at a rising edge, entry (`tblMap`, `tblPage`) takes `tblAttr`/`tblBase`. The new entry governs accesses from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU byte address |
| cpuRd | input | 1 | CPU read request |
| cpuWr | input | 1 | CPU write request |
| cpuM1 | input | 1 | Marks the read as an opcode fetch |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | Read data returned to the CPU |
| extOpen | input | 1 | Selects table pair 2/3 instead of 0/1 |
| tblWe | input | 1 | Page table load strobe |
| tblMap | input | 2 | Table index to load |
| tblPage | input | 7 | Page index to load |
| tblAttr | input | 2 | Attribute to load (00 RAM, 01 ROM, 1x empty) |
| tblBase | input | 8 | Physical page base to load |
| memAddr | output | 17 | Physical byte address |
| memRd | output | 1 | Physical read strobe |
| memWr | output | 1 | Physical write strobe |
| memWdata | output | 8 | Physical write data |
| memRdata | input | 8 | Physical read data |

## Verification
The hardest case to reach is the one-cycle lag between an opcode fetch and the table it steers. The fetch at 0x7800 must still be translated by the even table, and only the following access may use the odd one. The stimulus loads distinct bases into the even and odd tables for the same page. It then issues fetches at both edges of the window (0x77FF, 0x7800, 0x7FFF), places non-fetch writes at 0x7800, and pulses reset while the odd table is selected. The expected physical address then shows which table served each cycle.

// File: rtl/mmsel_pkg.sv
package mmsel_pkg;
  localparam int BASE_W = 8;

  typedef enum logic [1:0] {
    ATTR_RAM   = 2'b00,
    ATTR_ROM   = 2'b01,
    ATTR_EMPTY = 2'b10
  } pageAttr_e;

  typedef struct packed {
    pageAttr_e        attr;
    logic [BASE_W-1:0] base;
  } pageEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] mapSel;
    logic       rdReq;
    logic       wrReq;
  } mapStrobe_t;
endpackage

// File: rtl/mmsel_ctrl.sv
module mmsel_ctrl
  import mmsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ALT_MASK  = 16'hF800,
  parameter logic [ADDR_W-1:0] ALT_MATCH = 16'h7800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              cpuM1,
  input  logic              extOpen,
  output mapStrobe_t        strobe,
  output logic [ADDR_W-1:0] m1Addr
);
  logic altHit;

  // capture the address of each opcode fetch (R2, R7)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      m1Addr <= '0;
    end else if (cpuM1 && cpuRd) begin
      m1Addr <= cpuAddr;
    end
  end

  // selection comes from the captured value of earlier cycles (R3, R8)
  assign altHit = (m1Addr & ALT_MASK) == ALT_MATCH;

  always_comb begin
    strobe.mapSel = {extOpen, altHit};
    strobe.rdReq  = cpuRd;
    strobe.wrReq  = cpuWr;
  end
endmodule

// File: rtl/mmsel_data.sv
module mmsel_data
  import mmsel_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 9,
  parameter int MAP_CNT   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mapStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             cpuAddr,
  input  logic [7:0]                    cpuWdata,
  output logic [7:0]                    cpuRdata,
  input  logic                          tblWe,
  input  logic [$clog2(MAP_CNT)-1:0]    tblMap,
  input  logic [ADDR_W-PAGE_BITS-1:0]   tblPage,
  input  logic [1:0]                    tblAttr,
  input  logic [BASE_W-1:0]             tblBase,
  output logic [BASE_W+PAGE_BITS-1:0]   memAddr,
  output logic                          memRd,
  output logic                          memWr,
  output logic [7:0]                    memWdata,
  input  logic [7:0]                    memRdata
);
  localparam int PAGE_W   = ADDR_W - PAGE_BITS;
  localparam int PAGE_CNT = 1 << PAGE_W;

  pageEntry_t pageTbl [MAP_CNT][PAGE_CNT];
  pageEntry_t hitEntry;
  logic       isRam;
  logic       isRom;

  // table storage with load port (R7, R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int m = 0; m < MAP_CNT; m++) begin
        for (int p = 0; p < PAGE_CNT; p++) begin
          pageTbl[m][p].attr <= ATTR_RAM;
          pageTbl[m][p].base <= BASE_W'((m % 2) * PAGE_CNT + p);
        end
      end
    end else if (tblWe) begin
      pageTbl[tblMap][tblPage].attr <= pageAttr_e'(tblAttr);
      pageTbl[tblMap][tblPage].base <= tblBase;
    end
  end

  // lookup and gating (R1, R5, R6, R9)
  assign hitEntry = pageTbl[strobe.mapSel][cpuAddr[ADDR_W-1:PAGE_BITS]];
  assign isRam    = hitEntry.attr == ATTR_RAM;
  assign isRom    = hitEntry.attr == ATTR_ROM;

  always_comb begin
    memAddr  = {hitEntry.base, cpuAddr[PAGE_BITS-1:0]};
    memRd    = strobe.rdReq && (isRam || isRom);
    memWr    = strobe.wrReq && isRam;
    memWdata = cpuWdata;
    cpuRdata = (isRam || isRom) ? memRdata : 8'hFF;
  end
endmodule

// File: rtl/mmsel_top.sv
module mmsel_top
  import mmsel_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 9,
  parameter logic [ADDR_W-1:0] ALT_MASK  = 16'hF800,
  parameter logic [ADDR_W-1:0] ALT_MATCH = 16'h7800
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           cpuAddr,
  input  logic                        cpuRd,
  input  logic                        cpuWr,
  input  logic                        cpuM1,
  input  logic [7:0]                  cpuWdata,
  output logic [7:0]                  cpuRdata,
  input  logic                        extOpen,
  input  logic                        tblWe,
  input  logic [1:0]                  tblMap,
  input  logic [ADDR_W-PAGE_BITS-1:0] tblPage,
  input  logic [1:0]                  tblAttr,
  input  logic [BASE_W-1:0]           tblBase,
  output logic [BASE_W+PAGE_BITS-1:0] memAddr,
  output logic                        memRd,
  output logic                        memWr,
  output logic [7:0]                  memWdata,
  input  logic [7:0]                  memRdata
);
  mapStrobe_t        strobe;
  logic [ADDR_W-1:0] m1Addr;

  mmsel_ctrl #(.ADDR_W(ADDR_W), .ALT_MASK(ALT_MASK), .ALT_MATCH(ALT_MATCH)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuM1(cpuM1), .extOpen(extOpen), .strobe(strobe), .m1Addr(m1Addr)
  );

  mmsel_data #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .MAP_CNT(4)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .tblWe(tblWe), .tblMap(tblMap),
    .tblPage(tblPage), .tblAttr(tblAttr), .tblBase(tblBase), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata)
  );
endmodule

// File: rtl/mmsel_chk.sv
module mmsel_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic        cpuRd,
  input logic        cpuWr,
  input logic        cpuM1,
  input logic [7:0]  cpuRdata,
  input logic [16:0] memAddr,
  input logic        memRd,
  input logic        memWr,
  input logic [15:0] m1Addr
);
  assert_page_offset_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> memAddr[8:0] == cpuAddr[8:0]);

  assert_fetch_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuM1 && cpuRd) |=> m1Addr == $past(cpuAddr));

  assert_nonfetch_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuM1 && cpuRd) |=> $stable(m1Addr));

  assert_write_only_on_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> cpuWr);

  assert_empty_reads_ff_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !memRd) |-> cpuRdata == 8'hFF);

  assert_read_only_on_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> cpuRd);
endmodule

bind mmsel_top mmsel_chk chk_i (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .cpuM1(cpuM1), .cpuRdata(cpuRdata), .memAddr(memAddr), .memRd(memRd),
  .memWr(memWr), .m1Addr(m1Addr)
);

// File: tb/mmsel_top_tb_top.sv
module mmsel_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  // {m1, rd, wr, ext, addr}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b0100, 16'h0010}, {4'b0010, 16'h0005}, {4'b1100, 16'h7FFF},
    {4'b0100, 16'h7E01}, {4'b0010, 16'h7E02}, {4'b0011, 16'h0002},
    {4'b0101, 16'h0003}, {4'b1101, 16'h8000}, {4'b0011, 16'h0004},
    {4'b0101, 16'h0004}, {4'b1100, 16'h7000}, {4'b0100, 16'h8100},
    {4'b0010, 16'h7800}, {4'b0100, 16'h0000}, {4'b1100, 16'h77FF},
    {4'b0100, 16'h0000}, {4'b1100, 16'h7800}, {4'b0100, 16'h0000},
    {4'b0010, 16'hFFFF}, {4'b0000, 16'h1234}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0, cpuM1 = 1'b0, extOpen = 1'b0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic        tblWe = 1'b0;
  logic [1:0]  tblMap = '0;
  logic [6:0]  tblPage = '0;
  logic [1:0]  tblAttr = '0;
  logic [7:0]  tblBase = '0;
  logic [16:0] memAddr;
  logic        memRd, memWr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;

  int nTests = 0;
  int nFail = 0;
  logic [1:0]  mAttr [4][128];
  logic [7:0]  mBase [4][128];
  logic [15:0] mLatch;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memRdata = memAddr[7:0] ^ memAddr[16:9];

  mmsel_top dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuM1(cpuM1), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .extOpen(extOpen),
    .tblWe(tblWe), .tblMap(tblMap), .tblPage(tblPage), .tblAttr(tblAttr),
    .tblBase(tblBase), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  task automatic checkVal(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mLatch = '0;
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 128; p++) begin
        mAttr[m][p] = 2'b00;
        mBase[m][p] = 8'((m % 2) * 128 + p);
      end
  endtask

  task automatic applyIn(logic m1, logic rd, logic wr, logic ext, logic [15:0] a);
    cpuM1 = m1; cpuRd = rd; cpuWr = wr; extOpen = ext; cpuAddr = a;
    cpuWdata = a[7:0] ^ 8'h5A;
    #2;
  endtask

  task automatic modelCheck();
    int       mapI;
    logic [1:0] at;
    logic [16:0] pa;
    logic     live, ram;
    mapI = (extOpen ? 2 : 0) + (((mLatch & 16'hF800) == 16'h7800) ? 1 : 0);
    at   = mAttr[mapI][cpuAddr[15:9]];
    pa   = {mBase[mapI][cpuAddr[15:9]], cpuAddr[8:0]};
    ram  = at == 2'b00;
    live = ram || at == 2'b01;
    checkVal("R9 memRd", int'(memRd), int'(cpuRd && live));
    checkVal("R5 memWr", int'(memWr), int'(cpuWr && ram));
    if (cpuRd && live) checkVal("R1 memAddr", int'(memAddr), int'(pa));
    if (cpuWr && ram) begin
      checkVal("R1 memAddr", int'(memAddr), int'(pa));
      checkVal("R9 memWdata", int'(memWdata), int'(cpuWdata));
    end
    if (cpuRd)
      checkVal("R6 cpuRdata", int'(cpuRdata), live ? int'(pa[7:0] ^ pa[16:9]) : 'hFF);
  endtask

  task automatic endCycle();
    @(posedge clk);
    if (cpuM1 && cpuRd) mLatch = cpuAddr;
    @(negedge clk);
    cpuM1 = 0; cpuRd = 0; cpuWr = 0;
  endtask

  task automatic loadEntry(int m, int p, logic [1:0] at, logic [7:0] b);
    tblWe = 1; tblMap = 2'(m); tblPage = 7'(p); tblAttr = at; tblBase = b;
    @(posedge clk);
    mAttr[m][p] = at; mBase[m][p] = b;
    @(negedge clk);
    tblWe = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R7: reset state, idle and identity-like map 0
    applyIn(0, 0, 0, 0, 16'h0000);
    checkVal("R7 idle memRd", int'(memRd), 0);
    checkVal("R7 idle memWr", int'(memWr), 0);
    endCycle();
    applyIn(0, 1, 0, 0, 16'hFE00);
    checkVal("R7 reset entry", int'(memAddr), 'h0FE00);
    modelCheck(); endCycle();

    loadEntry(0, 0, 2'b00, 8'h10);
    loadEntry(1, 0, 2'b00, 8'h20);
    loadEntry(2, 0, 2'b01, 8'h30);
    loadEntry(3, 0, 2'b10, 8'h00);
    loadEntry(1, 'h3F, 2'b01, 8'hF0);
    loadEntry(0, 'h40, 2'b11, 8'h00);
    loadEntry(3, 'h40, 2'b00, 8'h44);
    applyIn(0, 1, 0, 0, 16'h0000);
    checkVal("R10 loaded entry", int'(memAddr), 'h02000);
    modelCheck(); endCycle();

    // R8: fetch at window start still uses the even table
    applyIn(1, 1, 0, 0, 16'h7800);
    checkVal("R8 fetch translation", int'(memAddr), 'h07800);
    modelCheck(); endCycle();
    applyIn(0, 1, 0, 0, 16'h0000);
    checkVal("R3 odd table", int'(memAddr), 'h04000);
    modelCheck(); endCycle();
    applyIn(0, 1, 0, 1, 16'h0200);
    checkVal("R4 pair 2/3", int'(memAddr), 'h10200);
    modelCheck(); endCycle();
    applyIn(0, 1, 0, 0, 16'h0010);
    endCycle();
    applyIn(0, 1, 0, 0, 16'h0000);
    checkVal("R2 plain read kept latch", int'(memAddr), 'h04000);
    modelCheck(); endCycle();

    for (int i = 0; i < NVEC; i++) begin
      applyIn(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0]);
      modelCheck();
      endCycle();
    end

    // R7: reset while the odd table is selected
    applyIn(1, 1, 0, 0, 16'h7800);
    endCycle();
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    modelReset();
    applyIn(0, 1, 0, 0, 16'h0000);
    checkVal("R7 latch cleared", int'(memAddr), 'h00000);
    modelCheck(); endCycle();

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule